// File: doc/BRIEF.md
# Timer/Event Counter with Pulse Capture

The block is an up-counter with a preload register. It can take its counting clock from three sources. In timer mode it counts a prescaled version of the system clock. In event mode it counts rising edges on an external pin. In capture mode it measures the width of a single high pulse on that pin. When the counter passes its all-ones value it reloads the preload value and keeps running. Each such overflow produces a one-cycle strobe for downstream logic and an interrupt request, which an enable bit can mask.

In capture mode the block is armed by setting the run bit. It starts counting prescaled ticks on the first rising edge of the pin and stops on the following falling edge. At that point the hardware clears the run bit, so the pulse length stays readable in the counter and the pin is ignored until software arms the block again. The pin passes through a synchronizer before edge detection. Software uses a simple register port. Reads are combinational.

Register map, by `rd_addr`/`wr_addr`:
- Address 0 is control: bits [2:0] select the prescale, bits [4:3] select the mode, bit 5 is run and bit 6 is the interrupt enable.
- Address 1 is the counter.
- Address 2 is the preload, and is read-only.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control, counter and preload registers read as zero, and `ovf_o` and `irq_o` are low.
- R2: A write to address 1 always loads the preload register. It also loads the counter only while the run bit (control bit 5) is 0. While the block is running, the counter keeps its value.
- R3: In timer mode (control bits [4:3] = 00) with run set, prescale field p (bits [2:0]) makes the counter advance once every 2^p clock cycles, for p = 0..7. The first advance comes 2^p cycles after run takes effect.
- R4: When the counter advances from all-ones, it loads the preload value instead and keeps counting. `ovf_o` is high for exactly that one cycle.
- R5: `irq_o` pulses in the same cycle as `ovf_o` only when the interrupt enable (control bit 6) is 1. Otherwise it stays low.
- R6: In event mode (bits [4:3] = 01) with run set, the counter advances once per rising edge of `ext_pin`, after a two-stage synchronizer. Falling edges and steady levels do not advance it.
- R7: In capture mode (bits [4:3] = 10) with run set, the counter advances on prescaled ticks only between a rising edge and the next falling edge of `ext_pin`. With prescale 0, a pulse high for N clock cycles adds N to the counter.
- R8: When a capture ends, the hardware clears the run bit. Later pulses on `ext_pin` leave the counter unchanged until software sets run again.
- R9: Capture responds to edges, not levels. If the pin is already high when the block is armed, nothing is counted: neither the high level nor the falling edge that follows. Counting begins at the next rising edge.
- R10: In hold mode (bits [4:3] = 11), the counter does not advance even with run set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WIDTH | Read data for `rd_addr`, combinational |
| ext_pin | input | 1 | External event / pulse input, asynchronous |
| ovf_o | output | 1 | One-cycle overflow strobe |
| irq_o | output | 1 | One-cycle interrupt request, masked by enable |

## Verification
The bench builds the block with its defaults: an 8-bit counter, a 3-bit prescale field and two synchronizer stages. With an 8-bit counter, overflow and reload are reached within tens of cycles from a high preload. The 3-bit prescale field lets the divide-by-8 and divide-by-2 ratios be checked exactly against a cycle count. Capture pulses of known width, a pin already high at arming and pulses after disarm are all driven at the two-stage synchronizer's fixed latency, so every expected count is exact.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_CAPT  = 2'b10,
    MODE_HOLD  = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_PRE  = 2'd2;

  localparam int CTRL_W = 7;
endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;
  localparam logic [DIV_W-1:0] ONES = '1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask  = ~(ONES << sel);
    tick  = en && ((div_q & mask) == mask);
    div_d = en ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && $past(en) && sel != '0 && $stable(sel)) |-> !$past(tick));
  assert_idle_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick || (sel == '0));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             run,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             irq_en,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] preload,
  output logic             cap_act,
  output logic             cap_end,
  output logic             ovf,
  output logic             irq
);
  logic [WIDTH-1:0] cnt_q, cnt_d, pre_q, pre_d;
  logic             act_q, act_d, ovf_q, ovf_d, irq_q, irq_d;
  logic             inc, full, in_capt;

  always_comb begin
    in_capt = run && (mode == MODE_CAPT);
    full    = (cnt_q == '1);
    unique case (mode)
      MODE_TIMER: inc = run && tick;
      MODE_EVENT: inc = run && ev_rise;
      MODE_CAPT:  inc = run && act_q && tick;
      default:    inc = 1'b0;
    endcase
    cap_end = in_capt && act_q && ev_fall;
    if (!in_capt)               act_d = 1'b0;
    else if (!act_q && ev_rise) act_d = 1'b1;
    else if (cap_end)           act_d = 1'b0;
    else                        act_d = act_q;
    pre_d = cnt_wr ? wr_data : pre_q;
    if (cnt_wr && !run) cnt_d = wr_data;
    else if (inc)       cnt_d = full ? pre_q : cnt_q + 1'b1;
    else                cnt_d = cnt_q;
    ovf_d = inc && full;
    irq_d = inc && full && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      act_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      act_q <= act_d;
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

  assign cnt     = cnt_q;
  assign preload = pre_q;
  assign cap_act = act_q;
  assign ovf     = ovf_q;
  assign irq     = irq_q;

  assert_reload_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == $past(pre_q));
  assert_irq_needs_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf);
  assert_frozen_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  assert_hold_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !cnt_wr) |=> $stable(cnt));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ext_pin,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_ni;
  logic [PSC_W-1:0] psc_q, psc_d;
  tmr_mode_e        mode_q, mode_d;
  logic             run_q, run_d, ie_q, ie_d;
  logic             ctrl_wr, cnt_wr, psc_en, tick;
  logic             ev_rise, ev_fall, cap_act, cap_end;
  logic [WIDTH-1:0] cnt, preload;
  logic [CTRL_W-1:0] ctrl_vec;
  logic             unused_wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign ctrl_wr      = wr_en && (wr_addr == ADDR_CTRL);
  assign cnt_wr       = wr_en && (wr_addr == ADDR_CNT);
  assign unused_wr_hi = ^wr_data[WIDTH-1:CTRL_W];

  always_comb begin
    psc_d  = psc_q;
    mode_d = mode_q;
    run_d  = run_q;
    ie_d   = ie_q;
    if (ctrl_wr) begin
      psc_d  = wr_data[PSC_W-1:0];
      mode_d = tmr_mode_e'(wr_data[4:3]);
      run_d  = wr_data[5];
      ie_d   = wr_data[6];
    end else if (cap_end) begin
      run_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      mode_q <= MODE_TIMER;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      mode_q <= mode_d;
      run_q  <= run_d;
      ie_q   <= ie_d;
    end
  end

  assign psc_en = run_q && ((mode_q == MODE_TIMER) || ((mode_q == MODE_CAPT) && cap_act));

  evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .pin(ext_pin), .rise(ev_rise), .fall(ev_fall)
  );

  evt_prescaler #(.SEL_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_ni), .en(psc_en), .sel(psc_q), .tick(tick)
  );

  evt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_ni), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .run(run_q), .mode(mode_q), .tick(tick), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .irq_en(ie_q), .cnt(cnt), .preload(preload), .cap_act(cap_act),
    .cap_end(cap_end), .ovf(ovf_o), .irq(irq_o)
  );

  assign ctrl_vec = {ie_q, run_q, mode_q, psc_q};

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL: rd_data = WIDTH'(ctrl_vec);
      ADDR_CNT:  rd_data = cnt;
      ADDR_PRE:  rd_data = preload;
      default:   rd_data = '0;
    endcase
  end

  assert_capture_disarms_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (cap_end && !ctrl_wr) |=> !run_q);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_ni |-> (!ovf_o && !irq_o));
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         ext_pin = 1'b0;
  logic         ovf_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int ovf_seen = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_pin(ext_pin), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  // monitor: pops expected reads and compares
  always @(posedge clk) begin
    if (ovf_o) ovf_seen++;
    if (irq_o) irq_seen++;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string tag);
    sb_item_t it;
    rd_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_int(input int act, input int e, input string tag);
    n_tests++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic pulse(input int hi);
    ext_pin = 1'b1;
    repeat (hi) @(negedge clk);
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // independent model of counting with reload
  task automatic model(input int start, input int pre, input int n,
                       output int fin, output int ovfs);
    fin = start; ovfs = 0;
    for (int i = 0; i < n; i++) begin
      if (fin == 255) begin fin = pre; ovfs++; end
      else fin = fin + 1;
    end
  endtask

  // run for (m+1) counting cycles, then stop with ctrl_stop
  task automatic run_for(input logic [W-1:0] ctrl_run, input logic [W-1:0] ctrl_stop, input int m);
    wr(2'd0, ctrl_run);
    repeat (m) @(negedge clk);
    wr(2'd0, ctrl_stop);
  endtask

  initial begin
    int fin, ovfs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 cnt");
    rd(2'd2, 8'h00, "R1 preload");
    chk_int(ovf_seen + irq_seen, 0, "R1 strobes low");

    // R3/R4/R5 timer div1, preload F0, ie=1
    wr(2'd1, 8'hF0);
    rd(2'd1, 8'hF0, "R2 stopped write loads counter");
    ovf_seen = 0; irq_seen = 0;
    run_for(8'h60, 8'h40, 39);
    model(8'hF0, 8'hF0, 40, fin, ovfs);
    rd(2'd1, W'(fin), "R3 R4 timer div1 count with reload");
    chk_int(ovf_seen, ovfs, "R4 overflow strobes");
    chk_int(irq_seen, ovfs, "R5 irq with enable");

    // R3 div8
    wr(2'd1, 8'h10);
    run_for(8'h23, 8'h03, 39);
    rd(2'd1, 8'h15, "R3 timer div8");

    // R3 div2 with odd window
    wr(2'd1, 8'h00);
    run_for(8'h21, 8'h01, 8);
    rd(2'd1, 8'h04, "R3 timer div2");

    // R5 masked irq, preload FE
    wr(2'd1, 8'hFE);
    ovf_seen = 0; irq_seen = 0;
    run_for(8'h20, 8'h00, 9);
    model(8'hFE, 8'hFE, 10, fin, ovfs);
    rd(2'd1, W'(fin), "R4 reload from FE");
    chk_int(ovf_seen, ovfs, "R5 overflow still strobes");
    chk_int(irq_seen, 0, "R5 irq masked");

    // R10 hold mode and R2 write while running
    wr(2'd1, 8'h42);
    wr(2'd0, 8'h38);
    repeat (20) @(negedge clk);
    rd(2'd1, 8'h42, "R10 hold mode no count");
    wr(2'd1, 8'h77);
    rd(2'd1, 8'h42, "R2 running write keeps counter");
    rd(2'd2, 8'h77, "R2 running write loads preload");
    wr(2'd0, 8'h00);

    // R6 event mode
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h28);
    for (int k = 0; k < 5; k++) pulse(3);
    rd(2'd1, 8'h15, "R6 five rising edges");
    ext_pin = 1'b1;
    repeat (12) @(negedge clk);
    rd(2'd1, 8'h16, "R6 level does not add");
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, 8'h16, "R6 falling edge ignored");
    wr(2'd0, 8'h00);

    // R7/R8 capture div1
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h30);
    repeat (4) @(negedge clk);
    rd(2'd1, 8'h00, "R7 armed idle");
    pulse(7);
    rd(2'd1, 8'h07, "R7 pulse width 7");
    rd(2'd0, 8'h10, "R8 run cleared by hardware");
    pulse(4);
    rd(2'd1, 8'h07, "R8 later pulse ignored");

    // R7 capture div2
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h31);
    pulse(8);
    rd(2'd1, 8'h04, "R7 capture div2");

    // R9 armed while pin high
    wr(2'd1, 8'h00);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h30);
    repeat (4) @(negedge clk);
    rd(2'd1, 8'h00, "R9 high level not counted");
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, 8'h00, "R9 falling edge ignored");
    rd(2'd0, 8'h30, "R9 still armed");
    pulse(5);
    rd(2'd1, 8'h05, "R9 next pulse measured");

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule